// File: doc/BRIEF.md
# Strap Capture and Clock Start-Up Sequencer

This block sits beside a clock synthesizer and decides, once per power-up, which processor clock frequency the part runs at and when its clock outputs may start. It waits for the processor's active-low power-good strobe. The first time that strobe is seen low, it captures the two frequency-select straps. One strap is an ordinary binary input. The other is a three-level input (low, mid, high) carried on two wires. After a normal capture, a timed delay runs and then the output-enable goes high. From the moment of capture, the straps and the strobe no longer affect the result.

A mid level on the three-level strap at capture puts the block in a sticky test mode instead, and the outputs are never enabled. In test mode the three-level strap is ignored. The binary strap keeps live, unregistered control of the test sub-mode: all outputs are either high impedance or the divided reference. Only a reset (power cycle) leaves test mode.

The latched two-bit code is decoded to a frequency in MHz. A control-register input selects a second table with every value doubled. The strobe and the straps pass through a synchronizer of `SYNC_STAGES` flops before the state machine sees them.

Top module: `strap_seq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `cpu_code`=0, `cpu_mhz`=0, `out_en`=0, `test_mode`=0 and `test_hiz`=0.
- R2: While `pwrgd_n` stays high, changes on `sel_a` and `sel_b` (a mid level included) leave every output at its reset value.
- R3: When `pwrgd_n` goes low, the straps are captured at the (`SYNC_STAGES`+1)-th rising edge at which `pwrgd_n` is low. After that edge, `cpu_code` = {`sel_a`, `sel_b` is high}.
- R4: One edge after capture, `cpu_mhz` shows the frequency for the code with `dbl_sel`=0: code 00 gives 100, 01 gives 200, 10 gives 133 and 11 gives 166.
- R5: With `dbl_sel`=1, the table becomes 00 gives 200, 01 gives 400, 10 gives 266 and 11 gives 333. `cpu_mhz` follows a change of `dbl_sel` one edge later.
- R6: After a normal capture, later changes on `pwrgd_n`, `sel_a` and `sel_b` have no effect on `cpu_code`, `cpu_mhz`, `test_mode` or `out_en`.
- R7: `out_en` rises exactly `DELAY_CYC` edges after the capture edge and stays high until reset.
- R8: If `sel_b` is 2'b01 (mid) at capture, `test_mode` goes high at the capture edge. In that case `out_en` stays low and `cpu_mhz` stays 0.
- R9: In test mode, `test_hiz` equals `sel_a` with no clock delay (1 means high impedance, 0 means divided reference), and `sel_b` has no effect.
- R10: Test mode persists until `rst`. After a reset, a capture with `sel_b` low or high gives normal operation.
- R11: The `sel_b` code 2'b11 is treated as high (the same as 2'b10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| pwrgd_n | input | 1 | Processor power-good strobe, active low |
| sel_a | input | 1 | Binary frequency-select strap |
| sel_b | input | 2 | Three-level strap: 00 low, 01 mid, 10 or 11 high |
| dbl_sel | input | 1 | Control-register bit that selects the doubled frequency table |
| cpu_code | output | 2 | Latched code {sel_a, sel_b high} |
| cpu_mhz | output | 9 | Decoded processor clock frequency in MHz, 0 until a normal capture |
| out_en | output | 1 | Clock outputs enabled (normal operation) |
| test_mode | output | 1 | Test clock mode is latched |
| test_hiz | output | 1 | In test mode: 1 means all outputs high impedance, 0 means divided reference |

## Verification
A stimulus applied just after edge e is seen by the state machine at edge e+3 (two synchronizer stages plus the capture register). So `cpu_code` and `test_mode` are due after edge e+3, `cpu_mhz` after e+4, and `out_en` after e+3+`DELAY_CYC`. A change on `dbl_sel` shows in `cpu_mhz` after the next edge, and `test_hiz` follows `sel_a` within the same cycle. The driver writes each expectation into the scoreboard with the absolute edge at which it is due. It also checks the cycle one edge earlier where the output must not have moved yet. The monitor samples at the falling edge and compares only the entries due at that edge.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

  localparam int MHZ_W = 9;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2,
    ST_TEST  = 2'd3
  } seq_state_t;

  localparam logic [1:0] LVL_MID = 2'b01;

  // A high level is either upper code; bit 1 alone marks it.
  function automatic logic lvl_is_high(input logic [1:0] lvl);
    return lvl[1];
  endfunction

  function automatic logic [MHZ_W-1:0] code_to_mhz(input logic [1:0] code,
                                                   input logic       dbl);
    logic [MHZ_W-1:0] base;
    case (code)
      2'b00:   base = 9'd100;
      2'b01:   base = 9'd200;
      2'b10:   base = 9'd133;
      default: base = 9'd166;
    endcase
    if (dbl) begin
      case (code)
        2'b00:   base = 9'd200;
        2'b01:   base = 9'd400;
        2'b10:   base = 9'd266;
        default: base = 9'd333;
      endcase
    end
    return base;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/strap_fsm.sv
module strap_fsm
  import strap_seq_pkg::*;
#(
  parameter int DELAY_CYC = 3600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pg_n_s,
  input  logic       a_s,
  input  logic [1:0] b_s,
  output logic [1:0] cpu_code,
  output logic       code_valid,
  output logic       test_mode,
  output logic       out_en
);

  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_WAIT;
      cnt        <= '0;
      cpu_code   <= 2'b00;
      code_valid <= 1'b0;
      test_mode  <= 1'b0;
      out_en     <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (!pg_n_s) begin
            if (b_s == LVL_MID) begin
              state     <= ST_TEST;
              test_mode <= 1'b1;
            end else begin
              state      <= ST_DELAY;
              cpu_code   <= {a_s, lvl_is_high(b_s)};
              code_valid <= 1'b1;
              cnt        <= '0;
            end
          end
        end
        ST_DELAY: begin
          if (cnt == LAST) begin
            state  <= ST_RUN;
            out_en <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= state;
      endcase
    end
  end

  // R7
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_en |=> out_en);

  // R8
  test_no_en_chk: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> (!out_en && !code_valid));

  // R10
  test_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> test_mode);

  // R6
  code_lock_chk: assert property (@(posedge clk) disable iff (rst)
    code_valid |=> (code_valid && $stable(cpu_code)));

endmodule

// File: rtl/freq_decode.sv
module freq_decode
  import strap_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       code,
  input  logic             valid,
  input  logic             dbl,
  output logic [MHZ_W-1:0] cpu_mhz
);

  always_ff @(posedge clk) begin
    if (rst)        cpu_mhz <= '0;
    else if (valid) cpu_mhz <= code_to_mhz(code, dbl);
    else            cpu_mhz <= '0;
  end

  // R4
  mhz_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(valid) |-> (cpu_mhz == '0));

  // R5
  mhz_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(valid) |-> (cpu_mhz >= 9'd100));

endmodule

// File: rtl/strap_seq_ctrl.sv
module strap_seq_ctrl
  import strap_seq_pkg::*;
#(
  parameter int DELAY_CYC   = 3600,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwrgd_n,
  input  logic             sel_a,
  input  logic [1:0]       sel_b,
  input  logic             dbl_sel,
  output logic [1:0]       cpu_code,
  output logic [MHZ_W-1:0] cpu_mhz,
  output logic             out_en,
  output logic             test_mode,
  output logic             test_hiz
);

  localparam int SW = 4;

  logic [SW-1:0] raw_in, syn_in;
  logic          code_valid;

  assign raw_in = {pwrgd_n, sel_a, sel_b};

  strap_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  strap_fsm #(.DELAY_CYC(DELAY_CYC)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .pg_n_s     (syn_in[3]),
    .a_s        (syn_in[2]),
    .b_s        (syn_in[1:0]),
    .cpu_code   (cpu_code),
    .code_valid (code_valid),
    .test_mode  (test_mode),
    .out_en     (out_en)
  );

  freq_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .code    (cpu_code),
    .valid   (code_valid),
    .dbl     (dbl_sel),
    .cpu_mhz (cpu_mhz)
  );

  // Sub-mode follows the binary strap without a clock, as required in test mode.
  assign test_hiz = test_mode & sel_a;

  // R9
  hiz_gate_chk: assert property (@(posedge clk) disable iff (rst)
    test_hiz |-> test_mode);

endmodule

// File: tb/test_strap_seq_ctrl.sv
`timescale 1ns/1ps
module test_strap_seq_ctrl;

  localparam int D = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwrgd_n = 1'b1;
  logic       sel_a = 1'b0;
  logic [1:0] sel_b = 2'b00;
  logic       dbl_sel = 1'b0;
  logic [1:0] cpu_code;
  logic [8:0] cpu_mhz;
  logic       out_en, test_mode, test_hiz;

  strap_seq_ctrl #(.DELAY_CYC(D), .SYNC_STAGES(2)) i_strap_seq_ctrl (
    .clk(clk), .rst(rst), .pwrgd_n(pwrgd_n), .sel_a(sel_a), .sel_b(sel_b),
    .dbl_sel(dbl_sel), .cpu_code(cpu_code), .cpu_mhz(cpu_mhz),
    .out_en(out_en), .test_mode(test_mode), .test_hiz(test_hiz)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    at;
    int    sig;
    int    val;
    string req;
  } exp_t;

  exp_t q[$];
  int   ecnt = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always @(posedge clk) ecnt <= ecnt + 1;

  function automatic int sig_val(input int s);
    case (s)
      0: return int'(cpu_code);
      1: return int'(cpu_mhz);
      2: return int'(out_en);
      3: return int'(test_mode);
      default: return int'(test_hiz);
    endcase
  endfunction

  function automatic string sig_name(input int s);
    case (s)
      0: return "cpu_code";
      1: return "cpu_mhz";
      2: return "out_en";
      3: return "test_mode";
      default: return "test_hiz";
    endcase
  endfunction

  // Monitor: compares every entry due after the edge just passed.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == ecnt) begin
        checks++;
        if (sig_val(q[i].sig) != q[i].val) begin
          errors++;
          $display("FAIL %s: %s at edge %0d actual %0d expected %0d",
                   q[i].req, sig_name(q[i].sig), ecnt, sig_val(q[i].sig), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic push(input int at, input int sig, input int val, input string req);
    exp_t e;
    e.at = at; e.sig = sig; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    pwrgd_n = 1'b1;
    dbl_sel = 1'b0;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(1);
  endtask

  task automatic run_normal(input logic a, input logic [1:0] b, input int code,
                            input int mhz_n, input int mhz_d, input string tag);
    int e;
    do_reset();
    sel_a = a; sel_b = b; pwrgd_n = 1'b0;
    e = ecnt;
    push(e + 2, 0, 0, "R3");
    push(e + 3, 0, code, tag);
    push(e + 3, 1, 0, "R4");
    push(e + 4, 1, mhz_n, tag);
    push(e + 3, 3, 0, "R8");
    push(e + 2 + D, 2, 0, "R7");
    push(e + 3 + D, 2, 1, "R7");
    push(e + 8 + D, 2, 1, "R7");
    step(5);
    // Straps and strobe move after capture: nothing may follow them (R6).
    sel_a = ~a; sel_b = ~b; pwrgd_n = 1'b1;
    step(2);
    pwrgd_n = 1'b0;
    step(2);
    e = ecnt;
    push(e + 3, 0, code, "R6");
    push(e + 3, 1, mhz_n, "R6");
    push(e + 3, 3, 0, "R6");
    step(4);
    dbl_sel = 1'b1;
    e = ecnt;
    push(e + 1, 1, mhz_d, "R5");
    step(2);
    dbl_sel = 1'b0;
    e = ecnt;
    push(e + 1, 1, mhz_n, "R5");
    step(D);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e;
    // R1: reset values
    step(2);
    e = ecnt;
    for (int s = 0; s < 5; s++) push(e + 1, s, 0, "R1");
    rst = 1'b0;
    for (int s = 0; s < 5; s++) push(e + 2, s, 0, "R1");
    step(2);

    // R2: straps move while the strobe stays high
    sel_a = 1'b1; sel_b = 2'b01;
    e = ecnt;
    push(e + 5, 3, 0, "R2");
    push(e + 5, 0, 0, "R2");
    push(e + 5, 1, 0, "R2");
    step(3);
    sel_b = 2'b10;
    e = ecnt;
    push(e + 4, 0, 0, "R2");
    push(e + 4, 2, 0, "R2");
    step(6);

    // R4 and R5: all four codes
    run_normal(1'b0, 2'b00, 0, 100, 200, "R4");
    run_normal(1'b0, 2'b10, 1, 200, 400, "R4");
    run_normal(1'b1, 2'b00, 2, 133, 266, "R4");
    run_normal(1'b1, 2'b10, 3, 166, 333, "R4");
    // R11: code 11 on the three-level strap is high
    run_normal(1'b0, 2'b11, 1, 200, 400, "R11");

    // R8: mid level at capture
    do_reset();
    sel_a = 1'b0; sel_b = 2'b01; pwrgd_n = 1'b0;
    e = ecnt;
    push(e + 2, 3, 0, "R8");
    push(e + 3, 3, 1, "R8");
    push(e + 3, 4, 0, "R9");
    push(e + 6 + D, 2, 0, "R8");
    push(e + 6 + D, 1, 0, "R8");
    step(5);
    // R9: binary strap drives the sub-mode directly
    sel_a = 1'b1;
    e = ecnt;
    push(e + 1, 4, 1, "R9");
    step(2);
    sel_b = 2'b00; pwrgd_n = 1'b1;
    e = ecnt;
    push(e + 4, 3, 1, "R9");
    push(e + 4, 4, 1, "R9");
    push(e + 4, 0, 0, "R9");
    step(5);
    sel_a = 1'b0;
    e = ecnt;
    push(e + 1, 4, 0, "R9");
    push(e + 1, 3, 1, "R10");
    step(D);

    // R10: reset leaves test mode; normal capture then works
    sel_b = 2'b10; sel_a = 1'b1;
    do_reset();
    e = ecnt;
    push(e + 1, 3, 0, "R10");
    pwrgd_n = 1'b0;
    push(e + 3, 0, 3, "R10");
    push(e + 3, 3, 0, "R10");
    push(e + 3 + D, 2, 1, "R10");
    step(D + 6);

    step(2);
    if (q.size() != 0) begin
      errors += q.size();
      $display("FAIL scoreboard: %0d expectations never compared (actual %0d, expected 0)",
               q.size(), q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule